// File: doc/BRIEF.md
# Low-Power Mode Wake-Up Controller

This block keeps track of which power state the processor is in: reset, normal execution, sleep, software standby, hardware standby, a deep mode in which every module clock is stopped, and a short exception-entry state. A request from normal execution, together with a 2-bit selector, moves the processor into one of the three software-entered low-power modes. The block then decides which interrupt requests may end that mode.

A wake-up can come from the non-maskable interrupt, eight external request lines, the 8-bit timer or the watchdog. A wake-up is refused while interrupts are globally disabled. It is also refused for any maskable source while the CPU mask is set, and for any source routed to the data-transfer engine rather than the CPU. An accepted wake-up passes through the exception-entry state and issues a one-cycle start pulse that carries a source code. The reset pin returns the processor to reset with no pulse. A low standby pin forces hardware standby from any state.

All inputs are taken as synchronous to `clk_i`. Both the mode and the pulse come from registers.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `rst_ni` is low, `mode_o` is 0 (reset), `exc_start_o` is 0 and `exc_code_o` is 0. From reset with both pins high, the next clock edge gives `mode_o` = 1 (normal).
- R2: In normal state (1), `enter_req_i` with `mode_sel_i` = 0, 1 or 2 gives `mode_o` = 2 (sleep), 3 (software standby) or 5 (all clocks stopped) one edge later. `mode_sel_i` = 3 is ignored, and the state stays 1.
- R3: Entry requests have no effect in any state other than normal.
- R4: In mode 2, 3 or 5, an eligible wake source gives `mode_o` = 6 (exception entry) at the next edge and `mode_o` = 1 at the edge after that. In normal state the same sources produce no pulse.
- R5: `exc_start_o` is high only while `mode_o` = 6, and for exactly one cycle. During that cycle `exc_code_o` is 1 for the non-maskable interrupt, k+2 for external line k, 10 for the timer and 11 for the watchdog. In every other cycle `exc_code_o` is 0.
- R6: When several eligible sources arrive in the same cycle, the non-maskable interrupt wins. After it come external lines 0 to 7 with the lowest index first, then the timer, then the watchdog.
- R7: While `irq_dis_i` is high, no source ends a low-power mode, not even the non-maskable interrupt.
- R8: While `cpu_mask_i` is high, every source except the non-maskable interrupt is blocked.
- R9: A set bit of `xfer_sel_i` blocks its source: bit k blocks external line k, bit 8 blocks the timer and bit 9 blocks the watchdog. The other sources stay eligible.
- R10: `stby_ni` low gives `mode_o` = 4 (hardware standby) at the next edge from any state. This takes priority over the reset pin and over every source.
- R11: In hardware standby with `stby_ni` high, the next edge gives `mode_o` = 0, and the edge after that gives 1.
- R12: `res_ni` low with `stby_ni` high gives `mode_o` = 0 at the next edge from any state, with no `exc_start_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nmi_i | input | 1 | Non-maskable interrupt request |
| ext_irq_i | input | N_IRQ | External interrupt request lines |
| tmr_irq_i | input | 1 | 8-bit timer interrupt request |
| wdt_irq_i | input | 1 | Watchdog interrupt request |
| irq_dis_i | input | 1 | Global interrupt disable |
| cpu_mask_i | input | 1 | CPU mask for all maskable sources |
| xfer_sel_i | input | N_IRQ+2 | Per-source routing to data transfer |
| res_ni | input | 1 | Reset pin, active low |
| enter_req_i | input | 1 | Low-power entry request |
| mode_sel_i | input | 2 | Target mode for entry |
| stby_ni | input | 1 | Standby pin, active low |
| mode_o | output | 3 | Current mode code |
| exc_start_o | output | 1 | Exception-handling start pulse |
| exc_code_o | output | CODE_W | Wake-up source code |

## Verification
Every result here comes from a register. A change on any input therefore appears on `mode_o`, `exc_start_o` and `exc_code_o` after exactly one rising edge, and a wake-up reaches normal state one edge after the pulse. The bench drives inputs on the falling edge and samples on the next falling edge. Each check thus looks at the state one edge after its stimulus. A second sample, one edge later, confirms the return to normal and that the pulse has cleared. Blocked wake-ups are checked by showing that the mode code stays where it was. Held conditions are checked again over several cycles.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [2:0] {
    PM_RESET  = 3'd0,
    PM_RUN    = 3'd1,
    PM_SLEEP  = 3'd2,
    PM_SWSTBY = 3'd3,
    PM_HWSTBY = 3'd4,
    PM_DEEP   = 3'd5,
    PM_EXC    = 3'd6
  } pm_mode_e;

  typedef enum logic [1:0] {
    SEL_SLEEP  = 2'd0,
    SEL_SWSTBY = 2'd1,
    SEL_DEEP   = 2'd2,
    SEL_RSVD   = 2'd3
  } pm_sel_e;

endpackage

// File: rtl/pm_wake_qual.sv
// Qualifies wake sources and encodes the winner.
module pm_wake_qual #(
  parameter int N_IRQ  = 8,
  parameter int CODE_W = 4
) (
  input  logic               nmi_i,
  input  logic [N_IRQ-1:0]   ext_irq_i,
  input  logic               tmr_irq_i,
  input  logic               wdt_irq_i,
  input  logic               irq_dis_i,
  input  logic               cpu_mask_i,
  input  logic [N_IRQ+1:0]   xfer_sel_i,
  output logic               wake_o,
  output logic [CODE_W-1:0]  code_o
);
  localparam int N_SRC = N_IRQ + 2;

  logic [N_SRC-1:0] src, elig;
  logic             nmi_ok;
  logic             any_mask;
  logic [CODE_W-1:0] mask_code;

  // bit layout matches xfer_sel_i: lines, then timer, then watchdog
  assign src      = {wdt_irq_i, tmr_irq_i, ext_irq_i};
  assign elig     = src & ~xfer_sel_i & {N_SRC{~(cpu_mask_i | irq_dis_i)}};
  assign nmi_ok   = nmi_i & ~irq_dis_i;
  assign any_mask = |elig;

  always_comb begin
    mask_code = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (elig[i]) mask_code = CODE_W'(i + 2);
    end
  end

  assign wake_o = nmi_ok | any_mask;
  assign code_o = nmi_ok ? CODE_W'(1) : mask_code;

endmodule

// File: rtl/pm_mode_fsm.sv
// Mode register, entry decode and registered exception pulse.
module pm_mode_fsm
  import pwr_mode_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              res_ni,
  input  logic              stby_ni,
  input  logic              enter_req_i,
  input  logic [1:0]        mode_sel_i,
  input  logic              wake_i,
  input  logic [CODE_W-1:0] code_i,
  output pm_mode_e          mode_o,
  output logic              exc_start_o,
  output logic [CODE_W-1:0] exc_code_o
);
  pm_mode_e          state_q, state_d;
  logic              start_d;
  logic [CODE_W-1:0] code_d;

  always_comb begin
    state_d = state_q;
    start_d = 1'b0;
    code_d  = '0;
    if (!stby_ni) begin
      state_d = PM_HWSTBY;
    end else if (!res_ni) begin
      state_d = PM_RESET;
    end else begin
      unique case (state_q)
        PM_RESET:  state_d = PM_RUN;
        PM_RUN: begin
          if (enter_req_i) begin
            case (pm_sel_e'(mode_sel_i))
              SEL_SLEEP:  state_d = PM_SLEEP;
              SEL_SWSTBY: state_d = PM_SWSTBY;
              SEL_DEEP:   state_d = PM_DEEP;
              default:    state_d = PM_RUN;
            endcase
          end
        end
        PM_SLEEP, PM_SWSTBY, PM_DEEP: begin
          if (wake_i) begin
            state_d = PM_EXC;
            start_d = 1'b1;
            code_d  = code_i;
          end
        end
        PM_HWSTBY: state_d = PM_RESET;
        PM_EXC:    state_d = PM_RUN;
        default:   state_d = PM_RESET;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= PM_RESET;
      exc_start_o <= 1'b0;
      exc_code_o  <= '0;
    end else begin
      state_q     <= state_d;
      exc_start_o <= start_d;
      exc_code_o  <= code_d;
    end
  end

  assign mode_o = state_q;

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int N_IRQ  = 8,
  parameter int CODE_W = $clog2(N_IRQ + 4)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              nmi_i,
  input  logic [N_IRQ-1:0]  ext_irq_i,
  input  logic              tmr_irq_i,
  input  logic              wdt_irq_i,
  input  logic              irq_dis_i,
  input  logic              cpu_mask_i,
  input  logic [N_IRQ+1:0]  xfer_sel_i,
  input  logic              res_ni,
  input  logic              enter_req_i,
  input  logic [1:0]        mode_sel_i,
  input  logic              stby_ni,
  output logic [2:0]        mode_o,
  output logic              exc_start_o,
  output logic [CODE_W-1:0] exc_code_o
);
  logic              wake;
  logic [CODE_W-1:0] wake_code;
  pm_mode_e          mode;

  pm_wake_qual #(.N_IRQ(N_IRQ), .CODE_W(CODE_W)) i_qual (
    .nmi_i      (nmi_i),
    .ext_irq_i  (ext_irq_i),
    .tmr_irq_i  (tmr_irq_i),
    .wdt_irq_i  (wdt_irq_i),
    .irq_dis_i  (irq_dis_i),
    .cpu_mask_i (cpu_mask_i),
    .xfer_sel_i (xfer_sel_i),
    .wake_o     (wake),
    .code_o     (wake_code)
  );

  pm_mode_fsm #(.CODE_W(CODE_W)) i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .res_ni      (res_ni),
    .stby_ni     (stby_ni),
    .enter_req_i (enter_req_i),
    .mode_sel_i  (mode_sel_i),
    .wake_i      (wake),
    .code_i      (wake_code),
    .mode_o      (mode),
    .exc_start_o (exc_start_o),
    .exc_code_o  (exc_code_o)
  );

  assign mode_o = mode;

endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk #(
  parameter int CODE_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              res_ni,
  input logic              stby_ni,
  input logic              irq_dis_i,
  input logic [2:0]        mode_o,
  input logic              exc_start_o,
  input logic [CODE_W-1:0] exc_code_o
);

  assert_boot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd0 && stby_ni && res_ni) |=> mode_o == 3'd1);

  assert_wake_origin_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(exc_start_o) |-> ($past(mode_o) == 3'd2 || $past(mode_o) == 3'd3 || $past(mode_o) == 3'd5));

  assert_exc_to_run_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd6 && stby_ni && res_ni) |=> mode_o == 3'd1);

  assert_pulse_once_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_start_o |=> !exc_start_o);

  assert_pulse_code_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_start_o |-> (exc_code_o != '0 && mode_o == 3'd6));

  assert_idle_code_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exc_start_o |-> exc_code_o == '0);

  assert_dis_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd5 && irq_dis_i && stby_ni && res_ni) |=> mode_o == 3'd5);

  assert_hwstby_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stby_ni |=> mode_o == 3'd4);

  assert_hw_exit_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd4 && stby_ni) |=> mode_o == 3'd0);

  assert_res_pin_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stby_ni && !res_ni) |=> (mode_o == 3'd0 && !exc_start_o));

endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(.CODE_W(CODE_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .res_ni      (res_ni),
  .stby_ni     (stby_ni),
  .irq_dis_i   (irq_dis_i),
  .mode_o      (mode_o),
  .exc_start_o (exc_start_o),
  .exc_code_o  (exc_code_o)
);

// File: tb/test_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module test_pwr_mode_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N_VEC = 16;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       nmi, tmr, wdt, dis, cmask, res_n, req, stby_n;
  logic [7:0] irq;
  logic [9:0] xsel;
  logic [1:0] sel;
  logic [2:0] mode;
  logic       start;
  logic [3:0] code;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_mode_ctrl i_pwr_mode_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .nmi_i(nmi), .ext_irq_i(irq),
    .tmr_irq_i(tmr), .wdt_irq_i(wdt), .irq_dis_i(dis), .cpu_mask_i(cmask),
    .xfer_sel_i(xsel), .res_ni(res_n), .enter_req_i(req), .mode_sel_i(sel),
    .stby_ni(stby_n), .mode_o(mode), .exc_start_o(start), .exc_code_o(code)
  );

  // {sel, nmi, irq[7:0], tmr, wdt, dis, mask, xsel[9:0], exp_mode, exp_code}
  localparam logic [31:0] VEC [N_VEC] = '{
    {2'd2, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 10'h000, 3'd6, 4'd1},
    {2'd2, 1'b0, 8'h08, 1'b0, 1'b0, 1'b0, 1'b0, 10'h000, 3'd6, 4'd5},
    {2'd2, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 10'h000, 3'd6, 4'd10},
    {2'd2, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 10'h000, 3'd6, 4'd11},
    {2'd2, 1'b0, 8'h21, 1'b1, 1'b0, 1'b0, 1'b0, 10'h000, 3'd6, 4'd2},
    {2'd2, 1'b1, 8'h80, 1'b0, 1'b0, 1'b0, 1'b0, 10'h000, 3'd6, 4'd1},
    {2'd2, 1'b0, 8'h04, 1'b0, 1'b1, 1'b0, 1'b0, 10'h000, 3'd6, 4'd4},
    {2'd2, 1'b1, 8'hFF, 1'b1, 1'b1, 1'b1, 1'b0, 10'h000, 3'd5, 4'd0},
    {2'd2, 1'b0, 8'h02, 1'b1, 1'b1, 1'b0, 1'b1, 10'h000, 3'd5, 4'd0},
    {2'd2, 1'b1, 8'h02, 1'b0, 1'b0, 1'b0, 1'b1, 10'h000, 3'd6, 4'd1},
    {2'd2, 1'b0, 8'h08, 1'b0, 1'b0, 1'b0, 1'b0, 10'h008, 3'd5, 4'd0},
    {2'd2, 1'b0, 8'h18, 1'b0, 1'b0, 1'b0, 1'b0, 10'h008, 3'd6, 4'd6},
    {2'd2, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 10'h100, 3'd5, 4'd0},
    {2'd0, 1'b0, 8'h40, 1'b0, 1'b0, 1'b0, 1'b0, 10'h000, 3'd6, 4'd8},
    {2'd1, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 10'h000, 3'd6, 4'd11},
    {2'd2, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 10'h200, 3'd6, 4'd10}
  };

  task automatic check(input string req_tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req_tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic quiet();
    nmi = 0; irq = '0; tmr = 0; wdt = 0; dis = 0; cmask = 0; xsel = '0;
    req = 0; sel = 2'd0;
  endtask

  task automatic to_run();
    quiet();
    res_n = 0; step();
    res_n = 1; step();
  endtask

  task automatic enter(input logic [1:0] s);
    req = 1; sel = s; step();
    req = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    quiet();
    res_n = 1; stby_n = 1;
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1 mode in reset", int'(mode), 0);
    check("R1 pulse in reset", int'(start), 0);
    check("R1 code in reset", int'(code), 0);
    rst_ni = 1'b1;
    step();
    check("R1 boot to normal", int'(mode), 1);

    // table: R2 R4 R5 R6 R7 R8 R9
    for (int v = 0; v < N_VEC; v++) begin
      logic [31:0] e;
      int tgt;
      e = VEC[v];
      to_run();
      enter(e[31:30]);
      tgt = (e[31:30] == 2'd0) ? 2 : (e[31:30] == 2'd1) ? 3 : 5;
      check("R2 table entry", int'(mode), tgt);
      nmi = e[29]; irq = e[28:21]; tmr = e[20]; wdt = e[19];
      dis = e[18]; cmask = e[17]; xsel = e[16:7];
      step();
      check("R4 R6 R7 R8 R9 table mode", int'(mode), int'(e[6:4]));
      check("R5 table pulse", int'(start), (e[3:0] != 0) ? 1 : 0);
      check("R5 table code", int'(code), int'(e[3:0]));
      quiet();
      step();
      if (e[6:4] == 3'd6) begin
        check("R4 return to normal", int'(mode), 1);
        check("R5 pulse one cycle", int'(start), 0);
      end
    end

    // R2 reserved selector
    to_run();
    enter(2'd3);
    check("R2 reserved select ignored", int'(mode), 1);

    // R3 entry ignored outside normal
    enter(2'd0);
    check("R2 sleep entry", int'(mode), 2);
    enter(2'd2);
    check("R3 entry ignored in sleep", int'(mode), 2);

    // R4 sources in normal give no pulse
    to_run();
    nmi = 1; irq = 8'hFF; step();
    check("R4 no wake in normal mode", int'(mode), 1);
    check("R4 no pulse in normal", int'(start), 0);
    quiet();

    // R7 held disable over several cycles
    to_run();
    enter(2'd2);
    nmi = 1; dis = 1;
    for (int k = 0; k < 3; k++) begin
      step();
      check("R7 disable holds deep", int'(mode), 5);
    end
    dis = 0; step();
    check("R7 release wakes", int'(mode), 6);
    check("R5 nmi code after release", int'(code), 1);
    quiet(); step();

    // R12 reset pin from deep, no pulse
    to_run();
    enter(2'd2);
    nmi = 1; res_n = 0; step();
    check("R12 reset pin mode", int'(mode), 0);
    check("R12 no pulse", int'(start), 0);
    quiet(); res_n = 1; step();
    check("R12 back to normal", int'(mode), 1);

    // R10 standby over reset pin and sources
    enter(2'd2);
    res_n = 0; stby_n = 0; nmi = 1; step();
    check("R10 hw standby from deep", int'(mode), 4);
    res_n = 1; step();
    check("R10 hw standby held", int'(mode), 4);
    check("R10 no pulse in standby", int'(start), 0);
    quiet();
    stby_n = 1; step();
    check("R11 leave to reset", int'(mode), 0);
    step();
    check("R11 then normal", int'(mode), 1);
    stby_n = 0; step();
    check("R10 hw standby from normal", int'(mode), 4);
    stby_n = 1; step(); step();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule